// File: doc/BRIEF.md
# Polyphase Scaler Coefficient Store

This block holds the filter coefficients for a 64-phase polyphase image scaler. It keeps four independent banks, selected by a 2-bit code: 0 is luma/RGB vertical, 1 is chroma vertical, 2 is luma/RGB horizontal and 3 is chroma horizontal. The host programs the store through two write strobes. The select strobe latches a target made of bank, phase and tap pair. The data strobe then writes an even-tap coefficient and an odd-tap coefficient, each with its own enable, to that target. Only phases 0 through 32 are stored. Phases 33 to 63 are rebuilt on read from phase 64-p, with the taps reversed.

Each bank has a pending copy and an active copy. Host writes always land in the pending copy, and the datapath always reads the active copy. The host raises an update-complete strobe. On the next frame boundary pulse, every pending copy is copied into its active copy and the update flag clears.

Coefficient memory power is modelled only as a handshake. The host requests that gating be disabled. A status output reports that the memory is powered after a fixed number of cycles. A data write made while that status is low is dropped and raises a sticky error.

Top module: `scl_coef_store`

## Requirements
- R1: After reset every stored coefficient, in both the pending and the active copy, is zero, and `rd_coef_o`, `pwr_on_o`, `wr_err_o` and `upd_pend_o` are all low.
- R2: A `sel_we_i` strobe latches bank, phase and tap pair. Every later `data_we_i` strobe writes to that target until the next select strobe.
- R3: For tap pair k, a data write stores `even_coef_i` at tap 2k when `even_en_i` is set and `odd_coef_i` at tap 2k+1 when `odd_en_i` is set. A tap whose enable is clear keeps its previous value.
- R4: A read of phase p from 0 to 32 returns stored phase p in tap order. A read of phase p from 33 to 63 returns stored phase 64-p with output tap t taken from stored tap n-1-t, where n is the effective tap count.
- R5: `rd_ntaps_i` gives the tap count n. Output taps at positions n and above read as zero. A value of 0, or a value above 4, is treated as 4.
- R6: Writes change only the pending copy. `upd_done_i` sets `upd_pend_o`. A `frame_i` pulse while `upd_pend_o` is high copies all four pending banks into the active copies and clears the flag, unless `upd_done_i` is high in the same cycle. A `frame_i` pulse while the flag is low changes nothing.
- R7: `rd_coef_o` is registered. It reflects the bank, phase and count presented at one rising edge, read from the active copy as it stood before that edge. Tap t occupies bits 16t+15 down to 16t.
- R8: `pwr_on_o` rises at the third consecutive rising edge at which `pwr_dis_i` is high. It falls at the first rising edge at which `pwr_dis_i` is low.
- R9: A data write is dropped, and `wr_err_o` is set, when `pwr_on_o` is low or the selected phase is above 32. `wr_err_o` then stays set until reset.
- R10: A write to one bank leaves the other three banks unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sel_we_i | input | 1 | Latch the write target |
| sel_bank_i | input | 2 | Target bank code |
| sel_phase_i | input | 6 | Target phase (0 to 32 are valid) |
| sel_pair_i | input | 1 | Target tap pair |
| data_we_i | input | 1 | Write a coefficient pair to the target |
| even_en_i | input | 1 | Enable for the even-tap coefficient |
| even_coef_i | input | 16 | Even-tap coefficient, signed fixed point |
| odd_en_i | input | 1 | Enable for the odd-tap coefficient |
| odd_coef_i | input | 16 | Odd-tap coefficient, signed fixed point |
| upd_done_i | input | 1 | Host marks the pending set as complete |
| frame_i | input | 1 | Frame boundary pulse |
| upd_pend_o | output | 1 | A completed update is waiting for a frame boundary |
| pwr_dis_i | input | 1 | Request that memory power gating be disabled |
| pwr_on_o | output | 1 | Coefficient memory is powered |
| wr_err_o | output | 1 | Sticky flag for a dropped write |
| rd_bank_i | input | 2 | Read bank code |
| rd_phase_i | input | 6 | Read phase, 0 to 63 |
| rd_ntaps_i | input | 3 | Tap count of the filter being read |
| rd_coef_o | output | 64 | Four tap coefficients of the active copy |

## Verification
Read data is due one rising edge after the read inputs are presented. Pending writes and bank swaps take effect at the edge where they are sampled, so a read presented after a swap edge returns the new set. `pwr_on_o` is due on the third edge with the request held and falls at the first edge after the request is withdrawn. `wr_err_o` is due one edge after a dropped write. The bench keeps a behavioural model that advances at every rising edge, always working from the state it had before that edge, and compares every output against that model at the following falling edge. This keeps each expected value aligned to the exact edge at which the design must produce it.

// File: rtl/scl_coef_pkg.sv
package scl_coef_pkg;
  localparam int NUM_BANKS = 4;
  localparam int BANK_W    = $clog2(NUM_BANKS);

  typedef enum logic [BANK_W-1:0] {
    BANK_Y_VERT = 2'd0,
    BANK_C_VERT = 2'd1,
    BANK_Y_HORZ = 2'd2,
    BANK_C_HORZ = 2'd3
  } bank_e;
endpackage

// File: rtl/scl_coef_pwr.sv
module scl_coef_pwr #(
  parameter int PWR_UP_CYC = 3
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic pwr_dis_i,
  output logic pwr_on_o
);
  localparam int CNT_W = $clog2(PWR_UP_CYC + 1);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(PWR_UP_CYC - 1);

  logic [CNT_W-1:0] cnt_q;
  logic             on_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      on_q  <= 1'b0;
    end else if (!pwr_dis_i) begin
      cnt_q <= '0;
      on_q  <= 1'b0;
    end else begin
      if (cnt_q != LAST) cnt_q <= cnt_q + 1'b1;
      on_q <= (cnt_q == LAST);
    end
  end

  assign pwr_on_o = on_q;

  // R8: withdrawing the request drops power status at the next edge
  a_r8_off_at_next_edge: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !pwr_dis_i |=> !pwr_on_o);
endmodule

// File: rtl/scl_coef_bank.sv
module scl_coef_bank #(
  parameter int NUM_PHASES = 64,
  parameter int MAX_TAPS   = 4,
  parameter int COEF_W     = 16
) (
  input  logic                              clk_i,
  input  logic                              rst_ni,
  input  logic                              wr_en_i,
  input  logic [$clog2(NUM_PHASES/2+1)-1:0] wr_idx_i,
  input  logic [$clog2(MAX_TAPS/2)-1:0]     wr_pair_i,
  input  logic                              even_en_i,
  input  logic [COEF_W-1:0]                 even_i,
  input  logic                              odd_en_i,
  input  logic [COEF_W-1:0]                 odd_i,
  input  logic                              swap_i,
  input  logic [$clog2(NUM_PHASES/2+1)-1:0] rd_idx_i,
  output logic [MAX_TAPS-1:0][COEF_W-1:0]   rd_row_o
);
  localparam int STORED = NUM_PHASES / 2 + 1;
  localparam int TAP_W  = $clog2(MAX_TAPS);

  typedef logic [MAX_TAPS-1:0][COEF_W-1:0] row_t;

  row_t pend_q [STORED];
  row_t act_q  [STORED];

  logic [TAP_W-1:0] ev_tap, od_tap;
  assign ev_tap = TAP_W'({wr_pair_i, 1'b0});
  assign od_tap = TAP_W'({wr_pair_i, 1'b1});

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < STORED; i++) begin
        pend_q[i] <= '0;
        act_q[i]  <= '0;
      end
    end else begin
      // swap samples the pending copy before this edge's write
      if (swap_i) act_q <= pend_q;
      if (wr_en_i) begin
        if (even_en_i) pend_q[wr_idx_i][ev_tap] <= even_i;
        if (odd_en_i)  pend_q[wr_idx_i][od_tap] <= odd_i;
      end
    end
  end

  assign rd_row_o = act_q[rd_idx_i];

  // R6: active copy only moves on a swap
  a_r6_active_holds: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!$past(swap_i) && $stable(rd_idx_i)) |-> $stable(rd_row_o));
endmodule

// File: rtl/scl_coef_rd.sv
module scl_coef_rd import scl_coef_pkg::*; #(
  parameter int NUM_PHASES = 64,
  parameter int MAX_TAPS   = 4,
  parameter int COEF_W     = 16
) (
  input  logic                                     clk_i,
  input  logic                                     rst_ni,
  input  logic [BANK_W-1:0]                        rd_bank_i,
  input  logic [$clog2(NUM_PHASES)-1:0]            rd_phase_i,
  input  logic [$clog2(MAX_TAPS+1)-1:0]            rd_ntaps_i,
  input  logic [NUM_BANKS-1:0][MAX_TAPS-1:0][COEF_W-1:0] rows_i,
  output logic [$clog2(NUM_PHASES/2+1)-1:0]        rd_idx_o,
  output logic [MAX_TAPS-1:0][COEF_W-1:0]          rd_coef_o
);
  localparam int PH_W    = $clog2(NUM_PHASES);
  localparam int HALF    = NUM_PHASES / 2;
  localparam int STORE_W = $clog2(HALF + 1);
  localparam int TAP_W   = $clog2(MAX_TAPS);

  typedef logic [MAX_TAPS-1:0][COEF_W-1:0] row_t;

  logic mirror;
  row_t row, nxt, rd_q;
  int   n_eff;

  always_comb begin
    mirror   = rd_phase_i > PH_W'(HALF);
    rd_idx_o = mirror ? STORE_W'(NUM_PHASES - int'(rd_phase_i)) : STORE_W'(rd_phase_i);
  end

  always_comb begin
    row   = rows_i[rd_bank_i];
    n_eff = (rd_ntaps_i == '0 || int'(rd_ntaps_i) > MAX_TAPS) ? MAX_TAPS : int'(rd_ntaps_i);
    for (int t = 0; t < MAX_TAPS; t++) begin
      if (t >= n_eff)  nxt[t] = '0;
      else if (mirror) nxt[t] = row[TAP_W'(n_eff - 1 - t)];
      else             nxt[t] = row[t];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rd_q <= '0;
    else         rd_q <= nxt;
  end

  assign rd_coef_o = rd_q;

  // R5: top tap blanked when the count is below the maximum
  a_r5_top_tap_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_ntaps_i != '0 && int'(rd_ntaps_i) < MAX_TAPS) |=> rd_coef_o[MAX_TAPS-1] == '0);
endmodule

// File: rtl/scl_coef_store.sv
module scl_coef_store import scl_coef_pkg::*; #(
  parameter int NUM_PHASES = 64,
  parameter int MAX_TAPS   = 4,
  parameter int COEF_W     = 16,
  parameter int PWR_UP_CYC = 3
) (
  input  logic                             clk_i,
  input  logic                             rst_ni,
  input  logic                             sel_we_i,
  input  logic [BANK_W-1:0]                sel_bank_i,
  input  logic [$clog2(NUM_PHASES)-1:0]    sel_phase_i,
  input  logic [$clog2(MAX_TAPS/2)-1:0]    sel_pair_i,
  input  logic                             data_we_i,
  input  logic                             even_en_i,
  input  logic [COEF_W-1:0]                even_coef_i,
  input  logic                             odd_en_i,
  input  logic [COEF_W-1:0]                odd_coef_i,
  input  logic                             upd_done_i,
  input  logic                             frame_i,
  output logic                             upd_pend_o,
  input  logic                             pwr_dis_i,
  output logic                             pwr_on_o,
  output logic                             wr_err_o,
  input  logic [BANK_W-1:0]                rd_bank_i,
  input  logic [$clog2(NUM_PHASES)-1:0]    rd_phase_i,
  input  logic [$clog2(MAX_TAPS+1)-1:0]    rd_ntaps_i,
  output logic [MAX_TAPS*COEF_W-1:0]       rd_coef_o
);
  localparam int PH_W    = $clog2(NUM_PHASES);
  localparam int HALF    = NUM_PHASES / 2;
  localparam int STORE_W = $clog2(HALF + 1);
  localparam int PAIR_W  = $clog2(MAX_TAPS / 2);

  bank_e             sel_bank_q;
  logic [PH_W-1:0]   sel_phase_q;
  logic [PAIR_W-1:0] sel_pair_q;
  logic              upd_q, err_q, pwr_on;
  logic              wr_ok, wr_bad, swap;

  logic [NUM_BANKS-1:0][MAX_TAPS-1:0][COEF_W-1:0] rows;
  logic [STORE_W-1:0]                             rd_idx;
  logic [MAX_TAPS-1:0][COEF_W-1:0]                rd_row;

  assign wr_ok  = data_we_i && pwr_on && (sel_phase_q <= PH_W'(HALF));
  assign wr_bad = data_we_i && !wr_ok;
  assign swap   = upd_q && frame_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sel_bank_q  <= BANK_Y_VERT;
      sel_phase_q <= '0;
      sel_pair_q  <= '0;
      upd_q       <= 1'b0;
      err_q       <= 1'b0;
    end else begin
      if (sel_we_i) begin
        sel_bank_q  <= bank_e'(sel_bank_i);
        sel_phase_q <= sel_phase_i;
        sel_pair_q  <= sel_pair_i;
      end
      upd_q <= upd_done_i || (upd_q && !frame_i);
      if (wr_bad) err_q <= 1'b1;
    end
  end

  scl_coef_pwr #(.PWR_UP_CYC(PWR_UP_CYC)) u_pwr (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .pwr_dis_i(pwr_dis_i),
    .pwr_on_o (pwr_on)
  );

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    scl_coef_bank #(
      .NUM_PHASES(NUM_PHASES),
      .MAX_TAPS  (MAX_TAPS),
      .COEF_W    (COEF_W)
    ) u_bank (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .wr_en_i  (wr_ok && (sel_bank_q == bank_e'(b))),
      .wr_idx_i (STORE_W'(sel_phase_q)),
      .wr_pair_i(sel_pair_q),
      .even_en_i(even_en_i),
      .even_i   (even_coef_i),
      .odd_en_i (odd_en_i),
      .odd_i    (odd_coef_i),
      .swap_i   (swap),
      .rd_idx_i (rd_idx),
      .rd_row_o (rows[b])
    );
  end

  scl_coef_rd #(
    .NUM_PHASES(NUM_PHASES),
    .MAX_TAPS  (MAX_TAPS),
    .COEF_W    (COEF_W)
  ) u_rd (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .rd_bank_i (rd_bank_i),
    .rd_phase_i(rd_phase_i),
    .rd_ntaps_i(rd_ntaps_i),
    .rows_i    (rows),
    .rd_idx_o  (rd_idx),
    .rd_coef_o (rd_row)
  );

  assign rd_coef_o  = rd_row;
  assign upd_pend_o = upd_q;
  assign pwr_on_o   = pwr_on;
  assign wr_err_o   = err_q;

  // R9: write while unpowered is flagged
  a_r9_gated_write_flags: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (data_we_i && !pwr_on_o) |=> wr_err_o);
  // R9: error flag is sticky
  a_r9_err_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_err_o |=> wr_err_o);
  // R6: completion strobe arms the swap
  a_r6_flag_sets: assert property (@(posedge clk_i) disable iff (!rst_ni)
    upd_done_i |=> upd_pend_o);
  // R6: flag consumed by the frame pulse
  a_r6_flag_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (frame_i && upd_pend_o && !upd_done_i) |=> !upd_pend_o);
endmodule

// File: tb/test_scl_coef_store.sv
module test_scl_coef_store;
  import scl_coef_pkg::*;

  localparam int CLK_PERIOD = 10;
  localparam int NPH   = 64;
  localparam int HALF  = 32;
  localparam int NTAP  = 4;
  localparam int PWRUP = 3;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        sel_we = 0, data_we = 0, even_en = 0, odd_en = 0;
  logic [1:0]  sel_bank = 0, rd_bank = 0;
  logic [5:0]  sel_phase = 0, rd_phase = 0;
  logic [0:0]  sel_pair = 0;
  logic [15:0] even_coef = 0, odd_coef = 0;
  logic        upd_done = 0, frame = 0, pwr_dis = 0;
  logic [2:0]  rd_ntaps = 0;
  logic        upd_pend, pwr_on, wr_err;
  logic [63:0] rd_coef;

  int checks = 0, fails = 0;
  string cur_tag = "R1 reset";

  always #(CLK_PERIOD/2) clk = ~clk;

  scl_coef_store i_scl_coef_store (
    .clk_i(clk), .rst_ni(rst_n),
    .sel_we_i(sel_we), .sel_bank_i(sel_bank), .sel_phase_i(sel_phase), .sel_pair_i(sel_pair),
    .data_we_i(data_we), .even_en_i(even_en), .even_coef_i(even_coef),
    .odd_en_i(odd_en), .odd_coef_i(odd_coef),
    .upd_done_i(upd_done), .frame_i(frame), .upd_pend_o(upd_pend),
    .pwr_dis_i(pwr_dis), .pwr_on_o(pwr_on), .wr_err_o(wr_err),
    .rd_bank_i(rd_bank), .rd_phase_i(rd_phase), .rd_ntaps_i(rd_ntaps),
    .rd_coef_o(rd_coef)
  );

  // ---------------- behavioural reference model ----------------
  int          m_pend [4][HALF+1][NTAP];
  int          m_act  [4][HALF+1][NTAP];
  int          m_sel_b, m_sel_p, m_sel_k;
  int          m_run;
  bit          m_on, m_err, m_flag;
  logic [63:0] m_rd;

  function automatic logic [63:0] model_read(int b, int p, int nt);
    logic [63:0] r = '0;
    int n = (nt == 0 || nt > NTAP) ? NTAP : nt;
    int q = (p > HALF) ? NPH - p : p;
    for (int t = 0; t < n; t++) begin
      int src = (p > HALF) ? n - 1 - t : t;
      r[t*16 +: 16] = 16'(m_act[b][q][src]);
    end
    return r;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      foreach (m_pend[b, p, t]) begin m_pend[b][p][t] = 0; m_act[b][p][t] = 0; end
      m_sel_b = 0; m_sel_p = 0; m_sel_k = 0;
      m_run = 0; m_on = 0; m_err = 0; m_flag = 0; m_rd = '0;
    end else begin
      m_rd = model_read(int'(rd_bank), int'(rd_phase), int'(rd_ntaps));
      if (m_flag && frame) m_act = m_pend;
      if (data_we) begin
        if (!m_on || m_sel_p > HALF) m_err = 1;
        else begin
          if (even_en) m_pend[m_sel_b][m_sel_p][2*m_sel_k]   = int'(even_coef);
          if (odd_en)  m_pend[m_sel_b][m_sel_p][2*m_sel_k+1] = int'(odd_coef);
        end
      end
      if (sel_we) begin
        m_sel_b = int'(sel_bank); m_sel_p = int'(sel_phase); m_sel_k = int'(sel_pair);
      end
      m_flag = upd_done || (m_flag && !frame);
      m_run  = pwr_dis ? ((m_run < PWRUP) ? m_run + 1 : m_run) : 0;
      m_on   = (m_run >= PWRUP);
    end
  end

  task automatic chk(string tag, logic [63:0] got, logic [63:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got %h expected %h at %0t", tag, got, exp, $time);
    end
  endtask

  // compare every output against the model between edges
  always @(negedge clk) begin
    if (rst_n) begin
      chk({cur_tag, (int'(rd_phase) > HALF) ? " R4 R7 rd_coef" : " R3 R7 rd_coef"}, rd_coef, m_rd);
      chk({cur_tag, " R8 pwr_on"}, 64'(pwr_on), 64'(m_on));
      chk({cur_tag, " R9 wr_err"}, 64'(wr_err), 64'(m_err));
      chk({cur_tag, " R6 upd_pend"}, 64'(upd_pend), 64'(m_flag));
    end
  end

  // ---------------- stimulus helpers ----------------
  function automatic logic [15:0] cval(int seed, int b, int p, int t);
    return 16'((seed * 977 + b * 5003 + p * 131 + t * 29 + 1) & 32'hFFFF);
  endfunction

  task automatic sel(int b, int p, int k);
    @(negedge clk);
    sel_we = 1; sel_bank = 2'(b); sel_phase = 6'(p); sel_pair = 1'(k);
    @(negedge clk);
    sel_we = 0;
  endtask

  task automatic dat(bit ee, int ev, bit oe, int od);
    @(negedge clk);
    data_we = 1; even_en = ee; even_coef = 16'(ev); odd_en = oe; odd_coef = 16'(od);
    @(negedge clk);
    data_we = 0; even_en = 0; odd_en = 0;
  endtask

  task automatic program_bank(int seed, int b, int taps);
    int pairs = (taps + 1) / 2;
    for (int p = 0; p <= HALF; p++)
      for (int k = 0; k < pairs; k++) begin
        bit last_odd = (taps % 2 == 1) && (k == pairs - 1);
        sel(b, p, k);
        dat(1, cval(seed, b, p, 2*k), !last_odd, cval(seed, b, p, 2*k+1));
      end
  endtask

  task automatic pulse_upd();
    @(negedge clk); upd_done = 1; @(negedge clk); upd_done = 0;
  endtask

  task automatic pulse_frame();
    @(negedge clk); frame = 1; @(negedge clk); frame = 0;
  endtask

  task automatic rd(int b, int p, int nt);
    @(negedge clk); rd_bank = 2'(b); rd_phase = 6'(p); rd_ntaps = 3'(nt);
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: got timeout expected completion");
    summary();
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1: reset state
    chk("R1 reset rd_coef", rd_coef, 64'h0);
    chk("R1 reset pwr_on", 64'(pwr_on), 0);
    chk("R1 reset wr_err", 64'(wr_err), 0);
    chk("R1 reset upd_pend", 64'(upd_pend), 0);

    // R9: write while gated is dropped
    cur_tag = "R9 gated write";
    sel(0, 5, 0);
    dat(1, 16'h1234, 1, 16'h5678);
    @(negedge clk);
    chk("R9 error raised after gated write", 64'(wr_err), 1);
    pulse_upd(); pulse_frame();
    rd(0, 5, 4); @(negedge clk);
    chk("R9 gated write left no data", rd_coef, 64'h0);

    // R8: power-up handshake timing
    cur_tag = "R8 power up";
    pwr_dis = 1;
    @(negedge clk); @(negedge clk);
    chk("R8 still gated after two edges", 64'(pwr_on), 0);
    @(negedge clk);
    chk("R8 powered after third edge", 64'(pwr_on), 1);

    // R2 R3 R10: program four banks with different tap counts
    cur_tag = "R2 R3 R10 program";
    program_bank(1, int'(BANK_Y_VERT), 4);
    program_bank(2, int'(BANK_C_VERT), 2);
    program_bank(3, int'(BANK_Y_HORZ), 3);
    program_bank(4, int'(BANK_C_HORZ), 4);
    // R2 persistence, R3 per-coefficient enables
    sel(3, 10, 1);
    dat(1, 16'hA001, 0, 16'hFFFF);
    dat(0, 16'hFFFF, 1, 16'hB002);

    // R6: nothing visible before the swap
    cur_tag = "R6 before swap";
    rd(0, 1, 4); @(negedge clk);
    chk("R6 pending data hidden before swap", rd_coef, 64'h0);
    pulse_upd();
    cur_tag = "R6 swap";
    pulse_frame();
    rd(3, 10, 4); @(negedge clk);
    chk("R3 R2 enables and persistent select", rd_coef[63:32], {16'hB002, 16'hA001});

    // R4 R5 R7 R10: full read sweep with varied counts
    cur_tag = "R4 R5 R10 sweep";
    for (int b = 0; b < 4; b++)
      for (int p = 0; p < NPH; p++)
        rd(b, p, (p * 3 + b) % 8);
    rd(0, 63, 4); @(negedge clk);
    chk("R4 phase 63 mirrors phase 1 reversed", rd_coef,
        {cval(1,0,1,0), cval(1,0,1,1), cval(1,0,1,2), cval(1,0,1,3)});
    rd(0, 32, 2); @(negedge clk);
    chk("R5 count 2 blanks upper taps", rd_coef, {32'h0, cval(1,0,32,1), cval(1,0,32,0)});

    // R6: frame with no completion changes nothing
    cur_tag = "R6 no swap";
    sel(1, 0, 0);
    dat(1, 16'h7EEE, 1, 16'h8111);
    pulse_frame();
    rd(1, 0, 2); @(negedge clk);
    chk("R6 frame without completion keeps old set", rd_coef, {32'h0, cval(2,1,0,1), cval(2,1,0,0)});
    cur_tag = "R6 second swap";
    pulse_upd(); pulse_frame();
    rd(1, 0, 2); @(negedge clk);
    chk("R6 second swap shows new set", rd_coef, {32'h0, 16'h8111, 16'h7EEE});
    // completion and frame together: flag stays set, no swap
    sel(1, 0, 0);
    dat(1, 16'h0101, 0, 0);
    @(negedge clk); upd_done = 1; frame = 1;
    @(negedge clk); upd_done = 0; frame = 0;
    rd(1, 0, 2); @(negedge clk);
    chk("R6 simultaneous strobe arms without swap", 64'(upd_pend), 1);
    pulse_frame();

    // R9: phase above 32 is dropped
    cur_tag = "R9 phase range";
    sel(0, 40, 0);
    dat(1, 16'hDEAD, 1, 16'hBEEF);
    pulse_upd(); pulse_frame();
    rd(0, 40, 4); rd(0, 24, 4); @(negedge clk);

    // R8: power drop, then dropped write
    cur_tag = "R8 power down";
    @(negedge clk); pwr_dis = 0;
    @(negedge clk);
    chk("R8 gated at first edge after release", 64'(pwr_on), 0);
    sel(2, 3, 0);
    dat(1, 16'h4444, 1, 16'h5555);
    pulse_upd(); pulse_frame();
    rd(2, 3, 4); @(negedge clk);
    chk("R9 write after power down dropped", rd_coef,
        {16'h0, cval(3,2,3,2), cval(3,2,3,1), cval(3,2,3,0)});
    repeat (3) @(negedge clk);

    summary();
    $finish;
  end
endmodule